// File: doc/BRIEF.md
# Bank Busy Tracker for Read-While-Write

This block sits between the host access path and the program/erase engine of a four-bank non-volatile array. On every cycle it maps the current access address to one of four banks. It also holds a record of which bank, if any, has a program or erase operation running. Host reads to an idle bank go to array data. Only a read aimed at the busy bank is sent to the status path. The other three banks can therefore be read at full speed while the fourth is being written.

The bank map is uneven. The top three address bits pick the bank. The first and last banks each own one pattern of these bits, and the two middle banks own three patterns each. The engine pulses a start strobe to claim the bank addressed in that cycle and pulses a done strobe to release it. Only one bank may be claimed at a time. A start while a bank is already claimed is refused, and so is a write strobe aimed at the claimed bank. A refusal is shown on a flag in the same cycle.

Top module: `rww_bank_guard`

## Requirements
- R1: Address bits [21:19] equal to 000 give bank index 0 on `bank_idx` in the same cycle, with no register in the path.
- R2: Bit patterns 001, 010 and 011 on address bits [21:19] give bank index 1 in the same cycle.
- R3: Bit patterns 100, 101 and 110 on address bits [21:19] give bank index 2 in the same cycle.
- R4: Bit pattern 111 on address bits [21:19] gives bank index 3 in the same cycle.
- R5: Address bits [18:0] have no effect on `bank_idx`.
- R6: After reset no bank is busy, so a read to any bank leaves `rd_status` at 0, which means array data.
- R7: When `op_start` is high, `op_done` is low and no bank is busy, the bank addressed in that cycle becomes busy from the next cycle on. From then on, a read to that bank drives `rd_status` to 1.
- R8: While one bank is busy, a read to any other bank leaves `rd_status` at 0.
- R9: `op_done` releases the busy bank. From the next cycle on, reads to that bank give `rd_status` 0.
- R10: When `op_start` is high while a bank is busy, `op_reject` is 1 in that cycle and the busy bank does not change.
- R11: When `op_start` and `op_done` are both high in the same cycle, `op_done` wins and every bank is idle in the next cycle.
- R12: When `wr_en` is high and addresses the busy bank, `op_reject` is 1. When `wr_en` addresses an idle bank, `op_reject` stays 0 unless R10 applies.
- R13: `rd_status` is 0 whenever `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 22 | Access address |
| rd_en | input | 1 | Host read strobe |
| wr_en | input | 1 | Host write strobe |
| op_start | input | 1 | Engine claims the addressed bank |
| op_done | input | 1 | Engine releases the busy bank |
| bank_idx | output | 2 | Decoded bank index, 0 to 3 |
| rd_status | output | 1 | 1 sends the current read to status, 0 sends it to array data |
| op_reject | output | 1 | The new operation aimed at a busy bank is refused |

## Verification
The hardest case to reach is a start and a done in the same cycle. This must be tried both against an idle tracker and against a bank that is already busy. In the busy case the start is refused while the done still releases the bank. Directed sequences set up each of these two starting states on purpose. After the simultaneous strobes they read the affected bank and one other bank, because the state is only visible through reads. A long random phase then mixes start, done, read and write strobes across all eight address patterns. A behavioural model is checked against the outputs in every cycle.

// File: rtl/rww_pkg.sv
package rww_pkg;

    localparam int ADDR_W    = 22;
    localparam int SEL_LSB   = 19;
    localparam int SEL_W     = 3;
    localparam int NUM_BANKS = 4;
    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int NUM_PAT   = 1 << SEL_W;

    typedef logic [BANK_W-1:0] bank_t;

    // Uneven map: the lowest and highest patterns own the outer banks,
    // and the middle banks split the patterns that remain.
    function automatic bank_t bank_of_pattern(input int unsigned pat);
        if (pat == 0)
            return bank_t'(0);
        else if (pat == NUM_PAT - 1)
            return bank_t'(NUM_BANKS - 1);
        else if (pat < NUM_PAT / 2)
            return bank_t'(1);
        else
            return bank_t'(2);
    endfunction

endpackage

// File: rtl/rww_bank_decode.sv
module rww_bank_decode
    import rww_pkg::*;
#(
    parameter int P_SEL_W = SEL_W
) (
    input  logic [P_SEL_W-1:0] sel,
    output bank_t              bank
);
    localparam int NPAT = 1 << P_SEL_W;

    bank_t pat_bank [NPAT];

    for (genvar p = 0; p < NPAT; p++) begin : g_pat
        assign pat_bank[p] = bank_of_pattern(p);
    end

    assign bank = pat_bank[sel];

endmodule

// File: rtl/rww_busy_track.sv
module rww_busy_track
    import rww_pkg::*;
#(
    parameter int P_BANKS = NUM_BANKS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  bank_t              bank,
    input  logic               op_start,
    input  logic               op_done,
    input  logic               wr_en,
    output logic [P_BANKS-1:0] busy,
    output logic               reject
);
    typedef struct packed {
        logic [P_BANKS-1:0] busy;
    } trk_t;

    trk_t st_d, st_q;
    logic any_busy;
    logic accept;

    assign any_busy = |st_q.busy;
    assign accept   = op_start && !any_busy;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < P_BANKS; b++) begin
            if (op_done)
                st_d.busy[b] = 1'b0;
            else if (accept && (int'(bank) == b))
                st_d.busy[b] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign busy   = st_q.busy;
    assign reject = (op_start && any_busy) || (wr_en && st_q.busy[bank]);

    // R10
    only_one_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.busy));

    // R9
    done_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> (st_q.busy == '0));

    // R7
    start_claims_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && !op_done && !any_busy) |=> st_q.busy[$past(bank)]);

    // R10
    refused_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && any_busy && !op_done) |=> $stable(st_q.busy));

endmodule

// File: rtl/rww_read_steer.sv
module rww_read_steer
    import rww_pkg::*;
#(
    parameter int P_BANKS = NUM_BANKS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  bank_t              bank,
    input  logic [P_BANKS-1:0] busy,
    output logic               to_status
);
    assign to_status = rd_en && busy[bank];

    // R13
    status_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        to_status |-> rd_en);

endmodule

// File: rtl/rww_bank_guard.sv
module rww_bank_guard
    import rww_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              op_start,
    input  logic              op_done,
    output logic [BANK_W-1:0] bank_idx,
    output logic              rd_status,
    output logic              op_reject
);
    logic [NUM_BANKS-1:0] busy_vec;
    bank_t                bank_w;

    rww_bank_decode #(.P_SEL_W(SEL_W)) u_decode (
        .sel  (addr[SEL_LSB +: SEL_W]),
        .bank (bank_w)
    );

    rww_busy_track #(.P_BANKS(NUM_BANKS)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .bank     (bank_w),
        .op_start (op_start),
        .op_done  (op_done),
        .wr_en    (wr_en),
        .busy     (busy_vec),
        .reject   (op_reject)
    );

    rww_read_steer #(.P_BANKS(NUM_BANKS)) u_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .bank      (bank_w),
        .busy      (busy_vec),
        .to_status (rd_status)
    );

    assign bank_idx = bank_w;

    // R1
    outer_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[SEL_LSB +: SEL_W] == '0) |-> (bank_idx == '0));

    // R4
    outer_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[SEL_LSB +: SEL_W] == '1) |-> (bank_idx == BANK_W'(NUM_BANKS - 1)));

    // R8
    other_bank_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !busy_vec[bank_idx]) |-> !rd_status);

endmodule

// File: tb/rww_bank_guard_bench.sv
module rww_bank_guard_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [21:0] addr = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0, op_start = 1'b0, op_done = 1'b0;
    logic [1:0]  bank_idx;
    logic        rd_status, op_reject;

    int n_vec = 0;
    int n_bad = 0;
    int ref_busy = -1;   // -1: idle, else the bank index that is busy
    bit finished = 0;

    always #10 clk = ~clk;  // 50 MHz

    rww_bank_guard u_rww_bank_guard (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .op_start(op_start), .op_done(op_done),
        .bank_idx(bank_idx), .rd_status(rd_status), .op_reject(op_reject)
    );

    function automatic int exp_bank(input int pat);
        case (pat)
            0:       return 0;
            1, 2, 3: return 1;
            4, 5, 6: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic string decode_tag(input int pat);
        case (exp_bank(pat))
            0:       return "R1";
            1:       return "R2";
            2:       return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, compare after settling, advance model.
    task automatic step(input int pat, input bit rd, input bit wr, input bit st,
                        input bit dn, input string tag);
        int    b;
        bit    e_stat, e_rej;
        string ts, tr;
        @(negedge clk);
        addr     = {pat[2:0], 19'($urandom)};
        rd_en    = rd;
        wr_en    = wr;
        op_start = st;
        op_done  = dn;
        #2;
        b      = exp_bank(pat);
        e_stat = rd && (ref_busy == b);
        e_rej  = (st && ref_busy >= 0) || (wr && ref_busy == b);
        if (tag != "") begin
            ts = tag; tr = tag;
        end else begin
            ts = !rd ? "R13" : (ref_busy == b ? "R7" : "R8");
            tr = st ? "R10" : "R12";
        end
        check(decode_tag(pat), "bank_idx", int'(bank_idx), b);
        check(ts, "rd_status", int'(rd_status), int'(e_stat));
        check(tr, "op_reject", int'(op_reject), int'(e_rej));
        if (dn)
            ref_busy = -1;
        else if (st && ref_busy < 0)
            ref_busy = b;
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: every pattern reads as array after reset (R1..R4 decode, R5 random low bits)
        for (int p = 0; p < 8; p++) step(p, 1, 0, 0, 0, "R6");

        // R7: claim bank 1 through pattern 2, then read it
        step(2, 0, 0, 1, 0, "R7");
        step(3, 1, 0, 0, 0, "R7");
        step(1, 1, 0, 0, 0, "R7");
        // R8: other banks stay on array data
        step(0, 1, 0, 0, 0, "R8");
        step(5, 1, 0, 0, 0, "R8");
        step(7, 1, 0, 0, 0, "R8");
        // R10: start to bank 3 is refused and bank 1 stays busy
        step(7, 0, 0, 1, 0, "R10");
        step(7, 1, 0, 0, 0, "R10");
        step(2, 1, 0, 0, 0, "R10");
        // R12: write to busy bank refused, write to idle bank accepted
        step(1, 0, 1, 0, 0, "R12");
        step(6, 0, 1, 0, 0, "R12");
        // R13: no read strobe, no status
        step(2, 0, 0, 0, 0, "R13");
        // R9: release
        step(4, 0, 0, 0, 1, "R9");
        step(3, 1, 0, 0, 0, "R9");
        // R11: start and done together from idle
        step(5, 0, 0, 1, 1, "R11");
        step(5, 1, 0, 0, 0, "R11");
        // R11: start and done together while busy
        step(0, 0, 0, 1, 0, "R7");
        step(6, 0, 0, 1, 1, "R11");
        step(0, 1, 0, 0, 0, "R11");
        step(6, 1, 0, 0, 0, "R11");

        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 99);
            step($urandom_range(0, 7), $urandom_range(0, 1), r < 20,
                 r >= 20 && r < 35, (r >= 30 && r < 38), "");
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule